// File: doc/BRIEF.md
# PCIe TLP Trace Capture Filter

This block sits beside a PCIe trace unit and decides, for each TLP header that passes, whether that header should be recorded. It takes the trace setup as static inputs: a 20-bit selection word, an 8-bit class mask, a 4-bit direction code and a record-format select. Each TLP arrives as a one-cycle descriptor. The descriptor holds the root-port index it came through, its requester ID, its class, whether it travels outbound, and, for inbound completions, which of the two completion sub-classes it belongs to.

The selection word works in one of two modes. In port mode, its low 16 bits are a bitmask of root ports, and any number of ports may be selected. In requester mode, the low 16 bits name exactly one requester ID. The meaning of the direction code changes with the record format, and some codes admit only one of the two inbound completion sub-classes. The block also checks the setup for combinations the trace unit cannot honour. While such a combination is present it raises an error flag and suppresses every capture.

Top module: `tlp_trace_filter`

## Requirements
- R1: `capture` is a register. It goes high on the clock edge that samples `tlp_valid` high for an accepted descriptor, and it is low in the cycle after any edge where `tlp_valid` is low. After reset it is low.
- R2: While `trace_en` is low, `capture` and `config_error` are both low one cycle later, whatever the other inputs are.
- R3: When `sel_word[19]` is 1 (port mode), a descriptor passes the source check only if `sel_word[tlp_port]` is 1. Several port bits may be set at the same time.
- R4: When `sel_word[19]` is 0 (requester mode), a descriptor passes the source check only if `tlp_rid` equals `sel_word[15:0]`.
- R5: Bits 18:16 of `sel_word` have no effect on `capture` or on `config_error`.
- R6: `tlp_class` is coded 0 = posted, 1 = non-posted, 2 = completion, 3 = other. A descriptor passes the class check only if `class_mask[tlp_class]` is 1. Class 3 never passes. Bits 7:3 of `class_mask` have no effect.
- R7: With `fmt_8dw` = 0, the accepted direction codes are: 0 = every inbound TLP; 1 = every outbound TLP; 2 = every outbound TLP, plus inbound requests and inbound completions with `tlp_cpl_b` = 1; 3 = every outbound TLP, plus inbound completions with `tlp_cpl_b` = 0.
- R8: With `fmt_8dw` = 1, the accepted direction codes are: 1 = every outbound TLP; 2 = inbound requests and inbound completions with `tlp_cpl_b` = 1; 3 = inbound completions with `tlp_cpl_b` = 0. Code 0 is reserved.
- R9: One cycle after the setup holds an illegal combination while `trace_en` is high, `config_error` is high and `capture` is low. The illegal combinations are: a reserved direction code (any code of 4 or more, or code 0 with `fmt_8dw` = 1); `class_mask[2:0]` equal to zero; or a code that admits outbound traffic while `class_mask[2:0]` does not hold exactly one set bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trace_en | input | 1 | Trace is running |
| fmt_8dw | input | 1 | Record format: 0 = 4DW, 1 = 8DW |
| sel_word | input | 20 | Bit 19 selects the mode, bits 15:0 hold the port mask or the requester ID |
| class_mask | input | 8 | Selected TLP classes |
| dir_code | input | 4 | Direction code |
| tlp_valid | input | 1 | Descriptor present this cycle |
| tlp_port | input | 4 | Root-port index of the source |
| tlp_rid | input | 16 | Requester ID |
| tlp_class | input | 2 | TLP class code |
| tlp_outbound | input | 1 | 1 = outbound, 0 = inbound |
| tlp_cpl_b | input | 1 | Inbound completion sub-class: 1 = B, 0 = A |
| capture | output | 1 | Registered capture strobe |
| config_error | output | 1 | Registered illegal-setup flag |

## Verification
The bench builds the block with its default parameters: a 16-bit selection value, which gives a 4-bit port index, and an 8-bit class mask. At these widths every port index can reach a mask bit, and the reserved bits of the selection word lie above bit 15. That lets the bench flip those reserved bits and show that the result does not change. The default widths also expose the full 4-bit direction space, so the bench can reach the reserved codes above 3 as well as the reserved 8DW code 0.

// File: rtl/tlp_filt_pkg.sv
// Shared types for the TLP trace filter.
// Assumes the class code is 2 bits wide and indexes the class mask directly.
package tlp_filt_pkg;

    typedef enum logic [1:0] {
        CLS_POSTED    = 2'd0,
        CLS_NONPOSTED = 2'd1,
        CLS_COMPL     = 2'd2,
        CLS_OTHER     = 2'd3
    } tlp_class_e;

    // What one direction code admits, after decoding for the record format.
    typedef struct packed {
        logic take_out;     // outbound TLPs of any class
        logic take_in_req;  // inbound posted and non-posted requests
        logic take_cpl_a;   // inbound completions, sub-class A
        logic take_cpl_b;   // inbound completions, sub-class B
        logic rsvd;         // code has no meaning for this format
    } dir_plan_t;

endpackage

// File: rtl/tlp_filt_dir_decode.sv
// Turns the direction code and record format into a plan of admitted traffic.
// Assumes only codes 0..3 carry meaning. Every other code is reported as reserved.
module tlp_filt_dir_decode
    import tlp_filt_pkg::*;
#(
    parameter int DIR_W = 4
) (
    input  logic             fmt_8dw,
    input  logic [DIR_W-1:0] dir_code,
    output dir_plan_t        plan
);
    // Per-format lookup of the direction code.
    always_comb begin
        plan = '{default: 1'b0};
        if (dir_code > DIR_W'(3)) begin
            plan.rsvd = 1'b1;
        end else if (!fmt_8dw) begin
            unique case (dir_code[1:0])
                2'd0: begin plan.take_in_req = 1'b1; plan.take_cpl_a = 1'b1; plan.take_cpl_b = 1'b1; end
                2'd1: plan.take_out = 1'b1;
                2'd2: begin plan.take_out = 1'b1; plan.take_in_req = 1'b1; plan.take_cpl_b = 1'b1; end
                default: begin plan.take_out = 1'b1; plan.take_cpl_a = 1'b1; end
            endcase
        end else begin
            unique case (dir_code[1:0])
                2'd0: plan.rsvd = 1'b1;
                2'd1: plan.take_out = 1'b1;
                2'd2: begin plan.take_in_req = 1'b1; plan.take_cpl_b = 1'b1; end
                default: plan.take_cpl_a = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/tlp_filt_cfg_check.sv
// Flags setups the trace unit cannot honour. The output is combinational.
// Assumes class mask bits 2:0 are the only meaningful ones.
module tlp_filt_cfg_check
    import tlp_filt_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  dir_plan_t         plan,
    input  logic [TYPE_W-1:0] class_mask,
    output logic              cfg_bad
);
    localparam int USED_W = 3;

    logic [USED_W-1:0] used_bits;
    logic [1:0]        used_cnt;

    // Counts the meaningful class bits and combines the error rules.
    always_comb begin
        used_bits = class_mask[USED_W-1:0];
        used_cnt  = 2'(used_bits[0]) + 2'(used_bits[1]) + 2'(used_bits[2]);
        cfg_bad   = plan.rsvd
                  | (used_bits == '0)
                  | (plan.take_out & (used_cnt != 2'd1));
    end
endmodule

// File: rtl/tlp_filt_match.sv
// Combinational match of one descriptor against source, class and direction.
// Assumes the port index fits inside the selection value field.
module tlp_filt_match
    import tlp_filt_pkg::*;
#(
    parameter int SEL_W  = 20,
    parameter int VAL_W  = 16,
    parameter int TYPE_W = 8,
    localparam int PORT_W = $clog2(VAL_W)
) (
    input  logic [SEL_W-1:0]  sel_word,
    input  logic [TYPE_W-1:0] class_mask,
    input  dir_plan_t         plan,
    input  logic [PORT_W-1:0] tlp_port,
    input  logic [VAL_W-1:0]  tlp_rid,
    input  logic [1:0]        tlp_class,
    input  logic              tlp_outbound,
    input  logic              tlp_cpl_b,
    output logic              hit
);
    localparam int MODE_BIT = SEL_W - 1;

    logic [VAL_W-1:0] sel_val;
    logic             src_ok;
    logic             cls_ok;
    logic             dir_ok;
    tlp_class_e       cls;

    // Source check: port bitmask or exact requester ID.
    always_comb begin
        sel_val = sel_word[VAL_W-1:0];
        src_ok  = sel_word[MODE_BIT] ? sel_val[tlp_port] : (tlp_rid == sel_val);
    end

    // Class and direction checks.
    always_comb begin
        cls    = tlp_class_e'(tlp_class);
        cls_ok = (cls != CLS_OTHER) && class_mask[tlp_class];
        if (tlp_outbound)           dir_ok = plan.take_out;
        else if (cls == CLS_COMPL)  dir_ok = tlp_cpl_b ? plan.take_cpl_b : plan.take_cpl_a;
        else                        dir_ok = plan.take_in_req;
        hit = src_ok & cls_ok & dir_ok;
    end
endmodule

// File: rtl/tlp_trace_filter.sv
// Top of the TLP trace filter. It registers the capture decision and the setup error flag.
// Assumes the setup inputs are stable while trace_en is high and descriptors last one cycle.
module tlp_trace_filter
    import tlp_filt_pkg::*;
#(
    parameter int SEL_W  = 20,
    parameter int VAL_W  = 16,
    parameter int TYPE_W = 8,
    parameter int DIR_W  = 4,
    localparam int PORT_W = $clog2(VAL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic              fmt_8dw,
    input  logic [SEL_W-1:0]  sel_word,
    input  logic [TYPE_W-1:0] class_mask,
    input  logic [DIR_W-1:0]  dir_code,
    input  logic              tlp_valid,
    input  logic [PORT_W-1:0] tlp_port,
    input  logic [VAL_W-1:0]  tlp_rid,
    input  logic [1:0]        tlp_class,
    input  logic              tlp_outbound,
    input  logic              tlp_cpl_b,
    output logic              capture,
    output logic              config_error
);
    localparam int MODE_BIT = SEL_W - 1;

    dir_plan_t plan;
    logic      cfg_bad;
    logic      hit;

    tlp_filt_dir_decode #(.DIR_W(DIR_W)) u_dir (
        .fmt_8dw (fmt_8dw),
        .dir_code(dir_code),
        .plan    (plan)
    );

    tlp_filt_cfg_check #(.TYPE_W(TYPE_W)) u_cfg (
        .plan      (plan),
        .class_mask(class_mask),
        .cfg_bad   (cfg_bad)
    );

    tlp_filt_match #(.SEL_W(SEL_W), .VAL_W(VAL_W), .TYPE_W(TYPE_W)) u_match (
        .sel_word    (sel_word),
        .class_mask  (class_mask),
        .plan        (plan),
        .tlp_port    (tlp_port),
        .tlp_rid     (tlp_rid),
        .tlp_class   (tlp_class),
        .tlp_outbound(tlp_outbound),
        .tlp_cpl_b   (tlp_cpl_b),
        .hit         (hit)
    );

    // Output registers for the capture strobe and the setup error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capture      <= 1'b0;
            config_error <= 1'b0;
        end else begin
            config_error <= trace_en & cfg_bad;
            capture      <= trace_en & tlp_valid & ~cfg_bad & hit;
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> (!capture && !config_error)); // R2
    AST_NO_VALID_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !tlp_valid |=> !capture); // R1
    AST_ERROR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && cfg_bad) |=> (config_error && !capture)); // R9
    AST_PORT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_word[MODE_BIT] && !sel_word[tlp_port]) |=> !capture); // R3
    AST_RID_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_word[MODE_BIT] && (tlp_rid != sel_word[VAL_W-1:0])) |=> !capture); // R4
    AST_CLASS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        ((tlp_class == 2'd3) || !class_mask[tlp_class]) |=> !capture); // R6
endmodule

// File: tb/tlp_trace_filter_bench.sv
// Table-driven bench for the TLP trace filter, followed by directed timing and reset checks.
module tlp_trace_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        trace_en;
    logic        fmt_8dw;
    logic [19:0] sel_word;
    logic [7:0]  class_mask;
    logic [3:0]  dir_code;
    logic        tlp_valid;
    logic [3:0]  tlp_port;
    logic [15:0] tlp_rid;
    logic [1:0]  tlp_class;
    logic        tlp_outbound;
    logic        tlp_cpl_b;
    logic        capture;
    logic        config_error;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tlp_trace_filter u_tlp_trace_filter (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .fmt_8dw(fmt_8dw),
        .sel_word(sel_word), .class_mask(class_mask), .dir_code(dir_code),
        .tlp_valid(tlp_valid), .tlp_port(tlp_port), .tlp_rid(tlp_rid),
        .tlp_class(tlp_class), .tlp_outbound(tlp_outbound), .tlp_cpl_b(tlp_cpl_b),
        .capture(capture), .config_error(config_error)
    );

    // Vector: {fmt, sel[20], mask[8], dir[4], port[4], rid[16], cls[2], outb, cplb, exp_cap, exp_err}
    localparam int NV = 27;
    localparam logic [58:0] VEC [0:NV-1] = '{
        {1'b0, 20'h80001, 8'h01, 4'd0, 4'd0, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 20'h80001, 8'h01, 4'd0, 4'd1, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 20'h80006, 8'h01, 4'd0, 4'd2, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 20'h00101, 8'h01, 4'd0, 4'd5, 16'h0101, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 20'h00101, 8'h01, 4'd0, 4'd5, 16'h0102, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 20'h70101, 8'h01, 4'd0, 4'd5, 16'h0101, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 20'h00101, 8'h05, 4'd0, 4'd0, 16'h0101, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 20'h00101, 8'h05, 4'd0, 4'd0, 16'h0101, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 20'h00101, 8'hFA, 4'd0, 4'd0, 16'h0101, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 20'h00101, 8'h02, 4'd1, 4'd0, 16'h0101, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b0, 20'h00101, 8'h02, 4'd1, 4'd0, 16'h0101, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 20'h00101, 8'h04, 4'd2, 4'd0, 16'h0101, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0},
        {1'b0, 20'h00101, 8'h04, 4'd2, 4'd0, 16'h0101, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 20'h00101, 8'h04, 4'd3, 4'd0, 16'h0101, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 20'h00101, 8'h04, 4'd3, 4'd0, 16'h0101, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b0, 20'h00101, 8'h04, 4'd0, 4'd0, 16'h0101, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 20'h00101, 8'h01, 4'd1, 4'd0, 16'h0101, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b1, 20'h00101, 8'h07, 4'd2, 4'd0, 16'h0101, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b1, 20'h00101, 8'h07, 4'd2, 4'd0, 16'h0101, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b1, 20'h00101, 8'h07, 4'd3, 4'd0, 16'h0101, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 20'h00101, 8'h07, 4'd3, 4'd0, 16'h0101, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b1, 20'h00101, 8'h01, 4'd0, 4'd0, 16'h0101, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 20'h00101, 8'h01, 4'd5, 4'd0, 16'h0101, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 20'h00101, 8'hF8, 4'd0, 4'd0, 16'h0101, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 20'h00101, 8'h03, 4'd1, 4'd0, 16'h0101, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
        {1'b0, 20'h00101, 8'h06, 4'd2, 4'd0, 16'h0101, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 20'h00101, 8'h07, 4'd0, 4'd0, 16'h0101, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0}
    };
    localparam string TAG [0:NV-1] = '{
        "R3", "R3", "R3", "R4", "R4", "R5", "R6", "R6", "R6",
        "R7", "R7", "R7", "R7", "R7", "R7", "R7",
        "R8", "R8", "R8", "R8", "R8",
        "R9", "R9", "R9", "R9", "R9", "R6"
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [58:0] v, input logic en, input logic vld);
        fmt_8dw      = v[58];
        sel_word     = v[57:38];
        class_mask   = v[37:30];
        dir_code     = v[29:26];
        tlp_port     = v[25:22];
        tlp_rid      = v[21:6];
        tlp_class    = v[5:4];
        tlp_outbound = v[3];
        tlp_cpl_b    = v[2];
        trace_en     = en;
        tlp_valid    = vld;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        apply(VEC[0], 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check("R1", "reset capture", capture, 1'b0);
        check("R9", "reset config_error", config_error, 1'b0);
        rst_n = 1'b1;
        apply(VEC[0], 1'b0, 1'b0);
        @(negedge clk);

        // Table walk: drive one vector, sample after one edge.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i], 1'b1, 1'b1);
            @(negedge clk);
            check(TAG[i], $sformatf("vec %0d capture", i), capture, VEC[i][1]);
            check(TAG[i], $sformatf("vec %0d config_error", i), config_error, VEC[i][0]);
        end

        // R1 timing: no capture before the edge, capture after it, drop once valid falls.
        apply(VEC[0], 1'b1, 1'b0);
        @(negedge clk);
        apply(VEC[0], 1'b1, 1'b1);
        #2;
        check("R1", "before edge", capture, 1'b0);
        @(negedge clk);
        check("R1", "one cycle after valid", capture, 1'b1);
        tlp_valid = 1'b0;
        @(negedge clk);
        check("R1", "valid low", capture, 1'b0);

        // R2: a bad setup and a matching descriptor with trace off give nothing.
        apply(VEC[21], 1'b0, 1'b1);
        @(negedge clk);
        check("R2", "off capture", capture, 1'b0);
        check("R2", "off config_error", config_error, 1'b0);
        apply(VEC[0], 1'b0, 1'b1);
        @(negedge clk);
        check("R2", "off matching capture", capture, 1'b0);

        // R5: reserved bits set in port mode keep the same result.
        apply(VEC[2], 1'b1, 1'b1);
        sel_word = 20'hF0006;
        @(negedge clk);
        check("R5", "port mode rsvd bits", capture, 1'b1);
        check("R5", "port mode rsvd err", config_error, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule